// File: doc/BRIEF.md
# Error Record Bank with Priority Overwrite

This block holds a single hardware error record. The record is a 64-bit status word and an optional address word. When an error event arrives at an empty bank, the event is stored as a fresh record. When an event arrives while a record is already held, a fixed priority rule picks which one event survives. The surviving record is always taken whole from one event, and fields from the two events are never mixed. The overflow flag is raised whether the new event is kept or dropped.

Software reads both words through a small register port and clears them. Any write to the status word clears it. The address word is cleared only by writing all zeros to it. A write that carries any 1 bit leaves the address word unchanged and raises a one-cycle fault pulse. If an event and a status clear fall in the same cycle, the clear takes effect first, so the event becomes a fresh record.

Top module: `err_log_bank`

## Requirements
- R1: During reset and right after it, the status word reads 0, the address word reads 0 and `wr_fault` is 0.
- R2: An event that reaches an empty bank is readable after the next rising edge. The status word then has valid (bit 63) = 1, overflow (bit 62) = 0, UC (bit 61) and address-valid (bit 58) equal to the event's flags, the color in bits 54:53, and the event code in the low `CODE_W` bits. All other bits are 0. The address word holds the event address when address-valid is 1, and 0 otherwise.
- R3: An event that arrives while a record is valid sets the overflow bit (62), whether that event is kept or dropped. The bit stays set until software clears the status word.
- R4: Color codes are 00 = unmonitored, 01 = green and 10 = yellow. When the held record is non-UC with color 00 or green, any non-UC event replaces the whole record.
- R5: When the held record is non-UC and yellow, a non-UC event is dropped and the record is unchanged apart from overflow. This applies even when both events are yellow, in which case the first is kept.
- R6: A UC event replaces a held non-UC record. This includes the address word, which becomes 0 when the new event has no address.
- R7: When the held record is UC, every later event is dropped, including another UC event.
- R8: Color code 11 is stored as 00 and is treated as 00 in the overwrite decision.
- R9: A write to the status word (`reg_sel` = 0) clears all 64 status bits, whatever the write data. The address word is not changed.
- R10: A write of all zeros to the address word (`reg_sel` = 1) clears it. A write with any 1 bit leaves it unchanged and drives `wr_fault` high for exactly the one cycle after the write edge.
- R11: An event in the same cycle as a status write is stored as a fresh record with overflow = 0.
- R12: `reg_rdata` shows the status word when `reg_sel` = 0. When `reg_sel` = 1 it shows the address word, zero-extended to 64 bits, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_vld | input | 1 | Error event strobe |
| evt_uc | input | 1 | Event is uncorrected |
| evt_color | input | 2 | Event health color code |
| evt_addr_vld | input | 1 | Event carries an address |
| evt_code | input | CODE_W | Event error code |
| evt_addr | input | ADDR_W | Event address |
| reg_wr | input | 1 | Software write strobe |
| reg_sel | input | 1 | 0 = status word, 1 = address word |
| reg_wdata | input | 64 | Software write data |
| reg_rdata | output | 64 | Read data for the selected word |
| wr_fault | output | 1 | One-cycle pulse for an illegal address write |

## Verification
Event capture and a software status clear can fall in the same rising edge. The bench provokes this by holding a valid record, then asserting a status write and an event strobe in one cycle. The result passes only if the status word reads back as a fresh record with overflow at 0. The bench also lines up an address-word write with a held record, and checks that a nonzero write leaves the captured address intact while the fault pulse appears for one cycle.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
  localparam int STAT_W    = 64;
  localparam int POS_VALID = 63;
  localparam int POS_OVF   = 62;
  localparam int POS_UC    = 61;
  localparam int POS_ADRV  = 58;
  localparam int POS_COLLO = 53;

  typedef enum logic [1:0] {
    COL_NONE   = 2'b00,
    COL_GREEN  = 2'b01,
    COL_YELLOW = 2'b10,
    COL_RSVD   = 2'b11
  } color_e;

  function automatic logic [1:0] norm_color(input logic [1:0] c);
    return (c == COL_RSVD) ? COL_NONE : c;
  endfunction
endpackage

// File: rtl/elog_arbiter.sv
module elog_arbiter (
  input  logic       held_uc,
  input  logic [1:0] held_color,
  input  logic       new_uc,
  output logic       replace
);
  import err_log_pkg::*;

  always_comb begin
    if (held_uc)
      replace = 1'b0;
    else if (new_uc)
      replace = 1'b1;
    else
      replace = (held_color != COL_YELLOW);
  end
endmodule

// File: rtl/elog_swport.sv
module elog_swport (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [63:0] reg_wdata,
  output logic        clr_stat,
  output logic        clr_addr,
  output logic        wr_fault
);
  logic fault_d;
  logic fault_q;

  always_comb begin
    clr_stat = reg_wr && !reg_sel;
    clr_addr = reg_wr && reg_sel && (reg_wdata == '0);
    fault_d  = reg_wr && reg_sel && (reg_wdata != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign wr_fault = fault_q;
endmodule

// File: rtl/elog_record.sv
module elog_record #(
  parameter int CODE_W = 16,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_vld,
  input  logic              evt_uc,
  input  logic [1:0]        evt_color,
  input  logic              evt_addr_vld,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              clr_stat,
  input  logic              clr_addr,
  output logic [63:0]       status,
  output logic [ADDR_W-1:0] addr
);
  import err_log_pkg::*;

  logic              valid_q, valid_d;
  logic              ovf_q, ovf_d;
  logic              uc_q, uc_d;
  logic              adrv_q, adrv_d;
  logic [1:0]        col_q, col_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              held_live;
  logic              replace;
  logic              take;
  logic              stat_en;
  logic              addr_en;

  elog_arbiter u_arb (
    .held_uc   (uc_q),
    .held_color(col_q),
    .new_uc    (evt_uc),
    .replace   (replace)
  );

  always_comb begin
    held_live = valid_q && !clr_stat;
    take      = evt_vld && (!held_live || replace);
    valid_d   = held_live;
    ovf_d     = ovf_q && !clr_stat;
    uc_d      = clr_stat ? 1'b0 : uc_q;
    adrv_d    = clr_stat ? 1'b0 : adrv_q;
    col_d     = clr_stat ? 2'b00 : col_q;
    code_d    = clr_stat ? '0 : code_q;
    addr_d    = addr_q;
    if (evt_vld) begin
      valid_d = 1'b1;
      ovf_d   = ovf_d || held_live;
    end
    if (take) begin
      uc_d   = evt_uc;
      adrv_d = evt_addr_vld;
      col_d  = norm_color(evt_color);
      code_d = evt_code;
      addr_d = evt_addr_vld ? evt_addr : '0;
    end else if (clr_addr) begin
      addr_d = '0;
    end
    stat_en = evt_vld || clr_stat;
    addr_en = take || clr_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
      uc_q    <= 1'b0;
      adrv_q  <= 1'b0;
      col_q   <= 2'b00;
      code_q  <= '0;
    end else if (stat_en) begin
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
      uc_q    <= uc_d;
      adrv_q  <= adrv_d;
      col_q   <= col_d;
      code_q  <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_comb begin
    status                          = '0;
    status[POS_VALID]               = valid_q;
    status[POS_OVF]                 = ovf_q;
    status[POS_UC]                  = uc_q;
    status[POS_ADRV]                = adrv_q;
    status[POS_COLLO+1:POS_COLLO]   = col_q;
    status[CODE_W-1:0]              = code_q;
  end

  assign addr = addr_q;
endmodule

// File: rtl/err_log_bank.sv
module err_log_bank #(
  parameter int CODE_W = 16,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_vld,
  input  logic              evt_uc,
  input  logic [1:0]        evt_color,
  input  logic              evt_addr_vld,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              wr_fault
);
  localparam int PAD_W = 64 - ADDR_W;

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic              clr_stat;
  logic              clr_addr;
  logic [63:0]       status_w;
  logic [ADDR_W-1:0] addr_w;
  logic [63:0]       addr_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  elog_swport u_sw (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .clr_stat (clr_stat),
    .clr_addr (clr_addr),
    .wr_fault (wr_fault)
  );

  elog_record #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_rec (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .evt_vld     (evt_vld),
    .evt_uc      (evt_uc),
    .evt_color   (evt_color),
    .evt_addr_vld(evt_addr_vld),
    .evt_code    (evt_code),
    .evt_addr    (evt_addr),
    .clr_stat    (clr_stat),
    .clr_addr    (clr_addr),
    .status      (status_w),
    .addr        (addr_w)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_ext = {{PAD_W{1'b0}}, addr_w};
    end else begin : g_full
      assign addr_ext = addr_w[63:0];
    end
  endgenerate

  assign reg_rdata = reg_sel ? addr_ext : status_w;
endmodule

// File: rtl/err_log_bank_chk.sv
module err_log_bank_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_vld,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [63:0]       reg_wdata,
  input logic              wr_fault,
  input logic [63:0]       status,
  input logic [ADDR_W-1:0] addr
);
  logic bad_addr_wr;
  logic stat_wr;
  assign bad_addr_wr = reg_wr && reg_sel && (reg_wdata != '0);
  assign stat_wr     = reg_wr && !reg_sel;

  assert_fresh_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && !status[63] && !stat_wr) |=> (status[63] && !status[62]));

  assert_overflow_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && status[63] && !stat_wr) |=> status[62]);

  assert_uc_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && status[63] && status[61] && !stat_wr)
      |=> (status[62] && $stable(status[61:0])));

  assert_no_rsvd_color_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[54:53] != 2'b11);

  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !evt_vld) |=> (status == 64'd0));

  assert_bad_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_addr_wr && !evt_vld) |=> ($stable(addr) && wr_fault));

  assert_fault_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> $past(bad_addr_wr));

  assert_clear_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && evt_vld) |=> (status[63] && !status[62]));
endmodule

bind err_log_bank err_log_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .evt_vld  (evt_vld),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .reg_wdata(reg_wdata),
  .wr_fault (wr_fault),
  .status   (status_w),
  .addr     (addr_w)
);

// File: tb/err_log_bank_tb.sv
`timescale 1ns/1ps
module err_log_bank_tb;
  localparam int CODE_W = 16;
  localparam int ADDR_W = 48;

  logic              clk;
  logic              rst_n;
  logic              evt_vld;
  logic              evt_uc;
  logic [1:0]        evt_color;
  logic              evt_addr_vld;
  logic [CODE_W-1:0] evt_code;
  logic [ADDR_W-1:0] evt_addr;
  logic              reg_wr;
  logic              reg_sel;
  logic [63:0]       reg_wdata;
  logic [63:0]       reg_rdata;
  logic              wr_fault;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  err_log_bank #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_uc(evt_uc),
    .evt_color(evt_color), .evt_addr_vld(evt_addr_vld), .evt_code(evt_code),
    .evt_addr(evt_addr), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_fault(wr_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       uc1;
    logic [1:0] c1;
    logic       uc2;
    logic [1:0] c2;
    logic       keep2;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd1, 1'b0, 2'd1, 1'b1},
    '{1'b0, 2'd1, 1'b0, 2'd2, 1'b1},
    '{1'b0, 2'd0, 1'b0, 2'd2, 1'b1},
    '{1'b0, 2'd2, 1'b0, 2'd1, 1'b0},
    '{1'b0, 2'd2, 1'b0, 2'd2, 1'b0},
    '{1'b0, 2'd2, 1'b1, 2'd0, 1'b1},
    '{1'b1, 2'd0, 1'b0, 2'd2, 1'b0},
    '{1'b1, 2'd1, 1'b1, 2'd2, 1'b0},
    '{1'b0, 2'd3, 1'b0, 2'd2, 1'b1},
    '{1'b0, 2'd2, 1'b0, 2'd3, 1'b0}
  };

  function automatic logic [63:0] exp_stat(input logic ovf, input logic uc,
                                           input logic [1:0] col, input logic adrv,
                                           input logic [CODE_W-1:0] code);
    logic [63:0] s;
    s        = '0;
    s[63]    = 1'b1;
    s[62]    = ovf;
    s[61]    = uc;
    s[58]    = adrv;
    s[54:53] = (col == 2'b11) ? 2'b00 : col;
    s[CODE_W-1:0] = code;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_vld = 0; evt_uc = 0; evt_color = 0; evt_addr_vld = 0;
    evt_code = '0; evt_addr = '0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    idle_inputs();
  endtask

  task automatic send_evt(input logic uc, input logic [1:0] col, input logic adrv,
                          input logic [CODE_W-1:0] code, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    evt_vld = 1; evt_uc = uc; evt_color = col; evt_addr_vld = adrv;
    evt_code = code; evt_addr = a;
    tick();
  endtask

  task automatic sw_write(input logic sel, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    tick();
  endtask

  task automatic rd(input logic sel, output logic [63:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [ADDR_W-1:0] a1;
    string t;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    rd(0, d); chk("R1 status in reset", d, 64'd0);
    rd(1, d); chk("R1 address in reset", d, 64'd0);
    chk("R1 fault in reset", {63'd0, wr_fault}, 64'd0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #2;
    rd(0, d); chk("R1 status after reset", d, 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [63:0] es;
      logic [63:0] ea;
      v  = VEC[i];
      a1 = 48'h0000_1234_5600 + 48'(i);
      sw_write(0, 64'hFFFF_0000_FFFF_0000);
      sw_write(1, 64'd0);
      send_evt(v.uc1, v.c1, 1'b1, 16'h1000 + 16'(i), a1);
      send_evt(v.uc2, v.c2, 1'b0, 16'h2000 + 16'(i), 48'hDEAD_BEEF);
      if (v.keep2) begin
        es = exp_stat(1'b1, v.uc2, v.c2, 1'b0, 16'h2000 + 16'(i));
        ea = 64'd0;
      end else begin
        es = exp_stat(1'b1, v.uc1, v.c1, 1'b1, 16'h1000 + 16'(i));
        ea = {16'd0, a1};
      end
      if (v.c1 == 2'd3 || v.c2 == 2'd3)     t = "R8";
      else if (v.uc1)                       t = "R7";
      else if (v.uc2)                       t = "R6";
      else if (!v.keep2)                    t = "R5";
      else                                  t = "R4";
      rd(0, d); chk($sformatf("%s+R3 vec %0d status", t, i), d, es);
      rd(1, d); chk($sformatf("%s+R12 vec %0d address", t, i), d, ea);
      // overflow stays set after a further dropped or kept event
      send_evt(1'b0, 2'd1, 1'b0, 16'h3000, 48'd0);
      rd(0, d); chk($sformatf("R3 vec %0d overflow sticky", i), {63'd0, d[62]}, 64'd1);
    end

    // R2: fresh capture with and without address
    sw_write(0, 64'd0);
    send_evt(1'b0, 2'd1, 1'b0, 16'h0055, 48'h0000_0000_ABCD);
    rd(0, d); chk("R2 fresh status no addr", d, exp_stat(0, 0, 2'd1, 0, 16'h0055));
    rd(1, d); chk("R2 address zero when no addr flag", d, 64'd0);
    sw_write(0, 64'd0);
    send_evt(1'b1, 2'd2, 1'b1, 16'h0077, 48'h8000_0000_0001);
    rd(0, d); chk("R2 fresh status with addr", d, exp_stat(0, 1, 2'd2, 1, 16'h0077));
    rd(1, d); chk("R2+R12 address captured", d, 64'h0000_8000_0000_0001);

    // R10: illegal address write
    @(negedge clk);
    reg_wr = 1; reg_sel = 1; reg_wdata = 64'h0000_0000_0000_0100;
    tick();
    chk("R10 fault pulse after bad write", {63'd0, wr_fault}, 64'd1);
    rd(1, d); chk("R10 address unchanged on bad write", d, 64'h0000_8000_0000_0001);
    @(posedge clk); #2;
    chk("R10 fault lasts one cycle", {63'd0, wr_fault}, 64'd0);
    sw_write(1, 64'd0);
    chk("R10 no fault on zero write", {63'd0, wr_fault}, 64'd0);
    rd(1, d); chk("R10 zero write clears address", d, 64'd0);

    // R9: status write clears all bits, address kept
    sw_write(0, 64'd0);
    send_evt(1'b0, 2'd2, 1'b1, 16'h0099, 48'h0000_0000_4444);
    sw_write(0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(0, d); chk("R9 status cleared by write", d, 64'd0);
    rd(1, d); chk("R9 address untouched by status write", d, 64'h0000_0000_0000_4444);

    // R11: event and status clear in the same cycle
    send_evt(1'b1, 2'd0, 1'b0, 16'h00AA, 48'd0);
    @(negedge clk);
    reg_wr = 1; reg_sel = 0; reg_wdata = 64'h1;
    evt_vld = 1; evt_uc = 0; evt_color = 2'd1; evt_addr_vld = 1;
    evt_code = 16'h00BB; evt_addr = 48'h0000_0000_7777;
    tick();
    rd(0, d); chk("R11 clear then fresh capture", d, exp_stat(0, 0, 2'd1, 1, 16'h00BB));
    rd(1, d); chk("R11 address of fresh record", d, 64'h0000_0000_0000_7777);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule